// File: doc/BRIEF.md
# Sector Frame Streamer with Carry-Chained Checksum

This block presents one disk sector to a host as a stream of bytes on a simple data port. On every read strobe it returns the next byte of a fixed 270-byte frame. The frame opens with a sync marker and a two-byte header made from the current track and sector numbers, which are captured when the frame starts. A run of zero padding follows, then the 256 payload bytes from an internal dual-port buffer, and last a one-byte checksum. The checksum is accumulated on the fly while the header, padding and payload bytes stream out, so no second pass over the buffer is needed before the final byte.

The same position counter serves a write path. Once a host arms the write latch, each write strobe stores one frame byte at the current position: payload positions land in the buffer and all other positions are discarded. After the 270th byte a one-cycle commit strobe marks the sector as complete. A write strobe with the latch clear is dropped and flagged. A separate preload port fills the buffer directly, for example from a media model.

Top module: `sector_framer`

## Requirements
- R1: A frame read from position 0 yields, at positions 0 to 269: 0xFF at position 0; at position 1 the `trk` value and at position 2 the `sec` value, both sampled on the read that starts the frame; 0x00 at positions 3 to 12; buffer entry p-13 at positions 13 to 268; the checksum at position 269.
- R2: The checksum is built from positions 1 to 268 in order. A sum and a carry both start at 0, and each step forms sum + byte + carry, keeping the low 8 bits as the new sum and bit 8 as the new carry. The byte at position 269 is the final sum.
- R3: A read strobe accepted on a clock edge places its byte on `rd_data`, with `rd_valid` high, two edges later. Back-to-back strobes deliver one byte per cycle, in position order.
- R4: `rd_busy` rises on the edge that accepts a read at position 0. It stays high until the edge that accepts the read of position 269, and falls on that edge.
- R5: A read at position 270 or beyond returns 0x00, leaves the position unchanged and leaves `rd_busy` low.
- R6: With the latch set, a write strobe stores `wr_data` at the current position and advances the position by one. Positions 13 to 268 go to buffer entry p-13, and later reads of the frame return the stored bytes.
- R7: A write strobe with the latch clear changes no state. `wr_err` is high for exactly the following cycle.
- R8: `commit` is high for one cycle, after the edge that accepts the write at position 269. On that same edge the latch clears.
- R9: `wr_arm` sets the latch and returns the position to 0. `ctl_abort` clears the latch and `rd_busy` and returns the position to 0. If both are high, arm wins. Read and write strobes in either of those cycles are ignored.
- R10: When read and write strobes are both high, the read is served. The write is dropped without `wr_err`.
- R11: After reset, `rd_valid`, `rd_busy`, `wr_latched`, `wr_err` and `commit` are all low.
- R12: `pre_we` writes `pre_din` into buffer entry `pre_addr`. A framer write to the same entry in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trk | input | 8 | Current track number |
| sec | input | 8 | Current sector number |
| rd_en | input | 1 | Read strobe for one frame byte |
| rd_data | output | 8 | Returned frame byte |
| rd_valid | output | 1 | rd_data holds a returned byte |
| rd_busy | output | 1 | A frame read is in progress |
| wr_en | input | 1 | Write strobe for one frame byte |
| wr_data | input | 8 | Frame byte to write |
| wr_arm | input | 1 | Set the write latch and restart the position |
| ctl_abort | input | 1 | Clear the write latch and busy flag and restart the position |
| wr_latched | output | 1 | Write latch state |
| wr_err | output | 1 | Pulse: a write was refused because the latch was clear |
| commit | output | 1 | Pulse: all 270 frame bytes have been written |
| pre_we | input | 1 | Buffer preload strobe |
| pre_addr | input | 8 | Buffer preload entry |
| pre_din | input | 8 | Buffer preload byte |

## Verification
The assertions assume that every strobe and control input is already synchronous to `clk`, and that each input is held low while reset is asserted. The read-latency property also assumes that `wr_arm` and `ctl_abort` never arrive in the same cycle as a read strobe they would cancel. The stimulus drives all inputs on the falling edge, holds them at zero through reset, and raises arm and abort only in cycles where no read or write strobe is high. The only exception is the directed case that checks the arm-over-abort priority.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    SEG_SYNC,
    SEG_TRK,
    SEG_SEC,
    SEG_PAD,
    SEG_DATA,
    SEG_SUM,
    SEG_PAST
  } seg_e;

  localparam logic [7:0] SYNC_MARK = 8'hFF;

  // Classify a frame position; lo is the first payload position, so is the checksum position.
  function automatic seg_e seg_of(input int unsigned pos, input int unsigned lo,
                                  input int unsigned so);
    if (pos == 0)       return SEG_SYNC;
    else if (pos == 1)  return SEG_TRK;
    else if (pos == 2)  return SEG_SEC;
    else if (pos < lo)  return SEG_PAD;
    else if (pos < so)  return SEG_DATA;
    else if (pos == so) return SEG_SUM;
    else                return SEG_PAST;
  endfunction

endpackage

// File: rtl/sfr_buf_ram.sv
module sfr_buf_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_r;

  // Port B is written after port A, so it wins on a same-entry collision.
  always_ff @(posedge clk) begin
    if (a_we)
      mem[a_addr] <= a_din;
    if (b_en && b_we)
      mem[b_addr] <= b_din;
  end

  always_ff @(posedge clk) begin
    if (b_en && !b_we)
      q_r <= mem[b_addr];
  end

  assign b_q = q_r;

endmodule

// File: rtl/sfr_csum.sv
module sfr_csum #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sum
);

  logic [DW-1:0] sum_q, sum_d;
  logic          cy_q, cy_d;
  logic          ld;

  always_comb begin
    sum_d = sum_q;
    cy_d  = cy_q;
    if (clr) begin
      sum_d = '0;
      cy_d  = 1'b0;
    end else if (en) begin
      {cy_d, sum_d} = {1'b0, sum_q} + {1'b0, din} + {{DW{1'b0}}, cy_q};
    end
  end

  assign ld = clr | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cy_q  <= 1'b0;
    end else if (ld) begin
      sum_q <= sum_d;
      cy_q  <= cy_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq #(
  parameter int unsigned DATA_BYTES = 256,
  parameter int unsigned PAD_BYTES  = 10,
  parameter int unsigned DW         = 8,
  localparam int unsigned DATA_LO   = 3 + PAD_BYTES,
  localparam int unsigned SUM_POS   = DATA_LO + DATA_BYTES,
  localparam int unsigned FRAME_END = SUM_POS + 1,
  localparam int unsigned CW        = $clog2(FRAME_END + 1),
  localparam int unsigned AW        = $clog2(DATA_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] trk,
  input  logic [DW-1:0] sec,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_arm,
  input  logic          ctl_abort,
  output logic          rd_acc,
  output logic [CW-1:0] rd_pos,
  output logic          frm_start,
  output logic [DW-1:0] hdr_trk,
  output logic [DW-1:0] hdr_sec,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_din,
  output logic          busy,
  output logic          latched,
  output logic          commit,
  output logic          err
);

  logic [CW-1:0] pos_q, pos_d, rel;
  logic          latch_q, latch_d;
  logic          busy_q, busy_d;
  logic          commit_q, err_q;
  logic [DW-1:0] trk_q, sec_q;
  logic          cmd, rd_go, rd_adv, wr_try, wr_go, wr_bad;
  logic          at_zero, at_last, in_data, pos_ld;

  always_comb begin
    cmd     = wr_arm | ctl_abort;
    rd_go   = rd_en & ~cmd;
    rd_adv  = rd_go & (pos_q < CW'(FRAME_END));
    wr_try  = wr_en & ~rd_en & ~cmd;
    wr_go   = wr_try & latch_q & (pos_q < CW'(FRAME_END));
    wr_bad  = wr_try & ~latch_q;
    at_zero = (pos_q == '0);
    at_last = (pos_q == CW'(SUM_POS));
    in_data = (pos_q >= CW'(DATA_LO)) && (pos_q < CW'(SUM_POS));
    rel     = pos_q - CW'(DATA_LO);
  end

  always_comb begin
    pos_d = pos_q;
    if (cmd)
      pos_d = '0;
    else if (rd_adv || wr_go)
      pos_d = pos_q + CW'(1);
    pos_ld = cmd | rd_adv | wr_go;
  end

  always_comb begin
    latch_d = latch_q;
    if (wr_arm)
      latch_d = 1'b1;
    else if (ctl_abort)
      latch_d = 1'b0;
    else if (wr_go && at_last)
      latch_d = 1'b0;
  end

  always_comb begin
    busy_d = busy_q;
    if (cmd)
      busy_d = 1'b0;
    else if (rd_adv && at_zero)
      busy_d = 1'b1;
    else if (rd_adv && at_last)
      busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      latch_q  <= 1'b0;
      busy_q   <= 1'b0;
      commit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (pos_ld)
        pos_q <= pos_d;
      latch_q  <= latch_d;
      busy_q   <= busy_d;
      commit_q <= wr_go & at_last;
      err_q    <= wr_bad;
    end
  end

  // Header is sampled once, on the read that opens the frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= '0;
      sec_q <= '0;
    end else if (rd_adv && at_zero) begin
      trk_q <= trk;
      sec_q <= sec;
    end
  end

  assign rd_acc    = rd_go;
  assign rd_pos    = pos_q;
  assign frm_start = rd_adv & at_zero;
  assign hdr_trk   = trk_q;
  assign hdr_sec   = sec_q;
  assign ram_en    = (rd_adv | wr_go) & in_data;
  assign ram_we    = wr_go;
  assign ram_addr  = rel[AW-1:0];
  assign ram_din   = wr_data;
  assign busy      = busy_q;
  assign latched   = latch_q;
  assign commit    = commit_q;
  assign err       = err_q;

endmodule

// File: rtl/sfr_emit.sv
module sfr_emit
  import sfr_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 256,
  parameter int unsigned PAD_BYTES  = 10,
  parameter int unsigned DW         = 8,
  localparam int unsigned DATA_LO   = 3 + PAD_BYTES,
  localparam int unsigned SUM_POS   = DATA_LO + DATA_BYTES,
  localparam int unsigned FRAME_END = SUM_POS + 1,
  localparam int unsigned CW        = $clog2(FRAME_END + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc,
  input  logic [CW-1:0] rd_pos,
  input  logic [DW-1:0] hdr_trk,
  input  logic [DW-1:0] hdr_sec,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] sum_q,
  output logic          sum_en,
  output logic [DW-1:0] sum_byte,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic          s1_vld_q;
  logic [CW-1:0] s1_pos_q;
  logic [DW-1:0] byte_d, data_q;
  logic          vld_q;
  seg_e          seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_pos_q <= '0;
    end else begin
      s1_vld_q <= rd_acc;
      if (rd_acc)
        s1_pos_q <= rd_pos;
    end
  end

  always_comb begin
    seg = seg_of(int'(s1_pos_q), DATA_LO, SUM_POS);
    unique case (seg)
      SEG_SYNC: byte_d = SYNC_MARK;
      SEG_TRK:  byte_d = hdr_trk;
      SEG_SEC:  byte_d = hdr_sec;
      SEG_DATA: byte_d = ram_q;
      SEG_SUM:  byte_d = sum_q;
      default:  byte_d = '0;
    endcase
    sum_en   = s1_vld_q && (seg inside {SEG_TRK, SEG_SEC, SEG_PAD, SEG_DATA});
    sum_byte = byte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= s1_vld_q;
      if (s1_vld_q)
        data_q <= byte_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = vld_q;

endmodule

// File: rtl/sector_framer.sv
module sector_framer #(
  parameter int unsigned DATA_BYTES = 256,
  parameter int unsigned PAD_BYTES  = 10,
  parameter int unsigned DW         = 8,
  localparam int unsigned DATA_LO   = 3 + PAD_BYTES,
  localparam int unsigned SUM_POS   = DATA_LO + DATA_BYTES,
  localparam int unsigned FRAME_END = SUM_POS + 1,
  localparam int unsigned CW        = $clog2(FRAME_END + 1),
  localparam int unsigned AW        = $clog2(DATA_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] trk,
  input  logic [DW-1:0] sec,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_busy,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_arm,
  input  logic          ctl_abort,
  output logic          wr_latched,
  output logic          wr_err,
  output logic          commit,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_din
);

  logic          rd_acc, frm_start, ram_en, ram_we, sum_en;
  logic [CW-1:0] rd_pos;
  logic [DW-1:0] hdr_trk, hdr_sec, ram_din, ram_q, sum_q, sum_byte;
  logic [AW-1:0] ram_addr;

  sfr_seq #(.DATA_BYTES(DATA_BYTES), .PAD_BYTES(PAD_BYTES), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .trk(trk), .sec(sec),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .wr_arm(wr_arm), .ctl_abort(ctl_abort),
    .rd_acc(rd_acc), .rd_pos(rd_pos), .frm_start(frm_start),
    .hdr_trk(hdr_trk), .hdr_sec(hdr_sec),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_din(ram_din),
    .busy(rd_busy), .latched(wr_latched), .commit(commit), .err(wr_err)
  );

  sfr_buf_ram #(.DEPTH(DATA_BYTES), .DW(DW)) u_buf (
    .clk(clk),
    .a_we(pre_we), .a_addr(pre_addr), .a_din(pre_din),
    .b_en(ram_en), .b_we(ram_we), .b_addr(ram_addr), .b_din(ram_din),
    .b_q(ram_q)
  );

  sfr_csum #(.DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(frm_start), .en(sum_en),
    .din(sum_byte), .sum(sum_q)
  );

  sfr_emit #(.DATA_BYTES(DATA_BYTES), .PAD_BYTES(PAD_BYTES), .DW(DW)) u_emit (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .rd_pos(rd_pos),
    .hdr_trk(hdr_trk), .hdr_sec(hdr_sec), .ram_q(ram_q), .sum_q(sum_q),
    .sum_en(sum_en), .sum_byte(sum_byte), .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic wr_en,
  input logic wr_arm,
  input logic ctl_abort,
  input logic rd_valid,
  input logic rd_busy,
  input logic wr_latched,
  input logic wr_err,
  input logic commit
);

  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en, 2));

  a_r4_busy_rises_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |-> ($past(rd_en) && !$past(wr_arm) && !$past(ctl_abort)));

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($past(wr_en) && !$past(wr_latched) && !$past(rd_en)));

  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r8_commit_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wr_latched);

  a_r9_arm_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> wr_latched);

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_abort && !wr_arm) |=> (!wr_latched && !rd_busy));

  a_r10_no_err_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && wr_err));

endmodule

bind sector_framer sfr_chk u_chk (.*);

// File: tb/sim_sector_framer.sv
module sim_sector_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] trk = '0, sec = '0, wr_data = '0, pre_addr = '0, pre_din = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, wr_arm = 1'b0, ctl_abort = 1'b0, pre_we = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, rd_busy, wr_latched, wr_err, commit;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] eframe [270];
  logic [7:0] cap [300];
  int capn = 0;

  // Vector: {track, sector, payload seed}; seed 00 = all zero, FF = all ones.
  localparam int NV = 5;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0,   8'd0,  8'h00},
    {8'd76,  8'd15, 8'hFF},
    {8'd12,  8'd3,  8'h35},
    {8'd200, 8'd9,  8'hC7},
    {8'd255, 8'd255,8'h01}
  };

  always #2 clk = ~clk;

  sector_framer u0 (.*);

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    if (seed == 8'h00) return 8'h00;
    if (seed == 8'hFF) return 8'hFF;
    return 8'((i * seed + (seed >> 1) + 7) & 255);
  endfunction

  function automatic logic [7:0] wpat(input int p);
    return 8'((p * 3 + 1) & 255);
  endfunction

  task automatic build_exp(input logic [7:0] t, input logic [7:0] s);
    logic [8:0] acc;
    logic [7:0] sm;
    logic cy;
    eframe[0] = 8'hFF; eframe[1] = t; eframe[2] = s;
    for (int p = 3; p < 13; p++) eframe[p] = 8'h00;
    for (int p = 13; p < 269; p++) eframe[p] = model[p-13];
    sm = '0; cy = 1'b0;
    for (int p = 1; p < 269; p++) begin
      acc = {1'b0, sm} + {1'b0, eframe[p]} + {8'b0, cy};
      sm = acc[7:0]; cy = acc[8];
    end
    eframe[269] = sm;
  endtask

  task automatic preload(input logic [7:0] seed);
    for (int i = 0; i < 256; i++) begin
      pre_we = 1'b1; pre_addr = 8'(i); pre_din = pat(seed, i);
      model[i] = pat(seed, i);
      @(negedge clk);
    end
    pre_we = 1'b0;
  endtask

  task automatic stream(input int n);
    for (int k = 0; k < n + 2; k++) begin
      rd_en = (k < n);
      @(negedge clk);
      if (rd_valid) begin
        cap[capn] = rd_data;
        capn++;
      end
    end
    rd_en = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit b);
    wr_arm = a; ctl_abort = b;
    @(negedge clk);
    wr_arm = 1'b0; ctl_abort = 1'b0;
  endtask

  task automatic compare_frame(input string tag);
    int bad = 0, first = -1;
    for (int p = 0; p < 270; p++)
      if (cap[p] !== eframe[p]) begin
        bad++;
        if (first < 0) first = p;
      end
    if (first < 0) first = 0;
    chk(bad == 0, tag, int'(cap[first]), int'(eframe[first]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!rd_valid && !rd_busy && !wr_latched && !wr_err && !commit, "R11 reset outputs",
        {rd_valid, rd_busy, wr_latched, wr_err, commit}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R12: table of frames
    for (int v = 0; v < NV; v++) begin
      pulse(1'b0, 1'b1);
      trk = VEC[v][23:16]; sec = VEC[v][15:8];
      preload(VEC[v][7:0]);
      build_exp(VEC[v][23:16], VEC[v][15:8]);
      capn = 0;
      stream(270);
      chk(capn == 270, "R3 byte count", capn, 270);
      compare_frame($sformatf("R1 R12 frame vector %0d", v));
      chk(cap[269] === eframe[269], $sformatf("R2 checksum vector %0d", v),
          int'(cap[269]), int'(eframe[269]));
    end

    // R3 latency
    pulse(1'b0, 1'b1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(!rd_valid, "R3 not valid after one edge", rd_valid, 0);
    chk(rd_busy, "R4 busy after first read", rd_busy, 1);
    @(negedge clk);
    chk(rd_valid && rd_data == 8'hFF, "R3 valid after two edges", {rd_valid, rd_data}, 9'h1FF);
    @(negedge clk);

    // R1 header sampled on first read, R4 busy lifetime
    pulse(1'b0, 1'b1);
    chk(!rd_busy, "R9 abort clears busy", rd_busy, 0);
    trk = 8'd5; sec = 8'd6;
    preload(8'h35);
    capn = 0;
    stream(1);
    trk = 8'd9; sec = 8'd1;
    stream(268);
    chk(rd_busy, "R4 busy before last byte", rd_busy, 1);
    stream(1);
    chk(!rd_busy, "R4 busy cleared after last byte", rd_busy, 0);
    build_exp(8'd5, 8'd6);
    compare_frame("R1 header held from first read");

    // R5 over-read
    capn = 0;
    stream(3);
    chk(capn == 3 && cap[0] == 0 && cap[1] == 0 && cap[2] == 0, "R5 over-read zero",
        {cap[0], cap[1], cap[2]}, 0);
    chk(!rd_busy, "R5 busy stays low", rd_busy, 0);

    // R6 R8 write path
    pulse(1'b1, 1'b0);
    chk(wr_latched, "R9 arm sets latch", wr_latched, 1);
    for (int p = 0; p < 269; p++) begin
      wr_en = 1'b1; wr_data = wpat(p);
      if (p >= 13) model[p-13] = wpat(p);
      @(negedge clk);
    end
    chk(!commit && wr_latched, "R8 no commit before last", {commit, wr_latched}, 1);
    wr_data = wpat(269);
    @(negedge clk);
    wr_en = 1'b0;
    chk(commit && !wr_latched, "R8 commit and latch clear", {commit, wr_latched}, 2);
    @(negedge clk);
    chk(!commit, "R8 commit single cycle", commit, 0);
    pulse(1'b0, 1'b1);
    trk = 8'd33; sec = 8'd7;
    build_exp(8'd33, 8'd7);
    capn = 0;
    stream(270);
    compare_frame("R6 written payload read back");

    // R7 refused write
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_err, "R7 error pulse", wr_err, 1);
    @(negedge clk);
    chk(!wr_err, "R7 error one cycle", wr_err, 0);
    pulse(1'b0, 1'b1);
    capn = 0;
    stream(14);
    chk(cap[13] === wpat(13), "R7 refused write left buffer", int'(cap[13]), int'(wpat(13)));

    // R10 read wins over write
    pulse(1'b1, 1'b0);
    rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk(!wr_err && rd_busy, "R10 read served without error", {wr_err, rd_busy}, 1);
    @(negedge clk);
    chk(rd_valid && rd_data == 8'hFF, "R10 read byte", {rd_valid, rd_data}, 9'h1FF);

    // R9 priority
    pulse(1'b1, 1'b1);
    chk(wr_latched, "R9 arm wins over abort", wr_latched, 1);
    pulse(1'b0, 1'b1);
    chk(!wr_latched, "R9 abort clears latch", wr_latched, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule